// File: doc/BRIEF.md
# Split/Cascade Interval Timer with External Restart and Gated Start

This block is an interval timer core with two counter halves. In split mode the halves are two separate up-counters, each with its own period register and its own one-cycle period flag. In cascade mode they form one wide counter: the low half feeds carries into the high half, and the two period registers together hold one wide period.

The primary time base (the low half in split mode, the whole wide counter in cascade mode) is the only one that reacts to an external event line and the only one that emits a sync-out pulse on its period match. One of 31 event lines is picked by a five-bit source code, and the code of all ones means "no source". The event line can act in one of two ways. In restart mode, a rising edge zeroes the primary count. In gated-start mode, the count is parked at zero until a rising edge arrives. The count then runs with a status bit set until software writes a clear strobe, which parks it again.

The gated-start control is a three-state machine. State IDLE_FREE is restart mode. State PARKED holds the count at zero while waiting. State RUNNING is a started count with status set. Its transitions are:
- enable_gate: IDLE_FREE to PARKED, when the gate-enable bit is 1.
- fire: PARKED to RUNNING, on an edge when no clear is written.
- rearm: RUNNING to PARKED, on a clear write.
- disable_gate: PARKED or RUNNING to IDLE_FREE, when the gate-enable bit is 0.

Top module: `duo_timer`

## Requirements
- R1: After reset, both counts read 0, all flags and the status read 0, both period registers hold all ones, split mode with restart behaviour is selected, and the source code is 31 (no source).
- R2: Register port: address 0 is control, with bit 0 = cascade, bit 1 = gate-enable, bits 6:2 = source code and bit 7 = clear strobe (not stored). Address 1 is the low/primary period and address 2 is the high/secondary period. A control write that changes bit 0 zeroes both counts.
- R3: In split mode the primary count rises by one per clock. Once it equals the low period, it reads 0 after the next clock. In that same cycle lo_flag and sync_out are 1 for exactly one cycle.
- R4: In split mode the secondary count runs against the high period in the same way and pulses hi_flag. It is never cleared by the event line, and it never drives sync_out.
- R5: In cascade mode the high count increments by one on each clock where the low count is all ones, and the low count rolls over to 0.
- R6: In cascade mode the period is {high period, low period}. A full match makes both counts read 0 after the next clock, with hi_flag and sync_out pulsing for one cycle. lo_flag stays 0 throughout cascade mode.
- R7: In restart mode, if the selected line goes high between clock edges k and k+1, the primary count reads 0 after edge k+2 and then counts on. A line that stays high has no further effect.
- R8: Source code 31 selects no line: rising edges on any event line leave the count untouched.
- R9: In gated-start mode the primary count is held at 0 while parked. An edge moves the block to RUNNING after edge k+2, with the count at 0 and trig_status at 1. It then counts up and keeps running after the line falls.
- R10: When a restart and a period wrap fall in the same cycle, the restart wins and no period flag or sync-out pulse is produced.
- R11: A control write with the clear strobe set makes trig_status 0 and the primary count 0 after that clock. The count stays at 0 until the next edge.
- R12: A clear write captured at the same clock as an event edge wins: the block stays parked with status 0 and count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| sync_in | input | 31 | Candidate event lines |
| cnt_lo_o | output | 16 | Low/primary count |
| cnt_hi_o | output | 16 | High/secondary count |
| lo_flag | output | 1 | Primary period pulse (split mode) |
| hi_flag | output | 1 | Secondary period pulse, or full-width match pulse in cascade mode |
| sync_out | output | 1 | Primary time-base match pulse |
| trig_status | output | 1 | Gated-start running status |

## Verification
The assertions assume that the event lines are synchronous to the clock. They also assume that a newly selected line is low when the source code changes, since otherwise the switch itself reads as an edge. The stimulus lowers every event line before each control write that changes the source code, issues at most one register write per cycle, and raises lines only after the mode and period writes have settled.

// File: rtl/duo_timer_pkg.sv
package duo_timer_pkg;

    typedef enum logic [1:0] {
        GS_IDLE_FREE = 2'd0,
        GS_PARKED    = 2'd1,
        GS_RUNNING   = 2'd2
    } gate_st_t;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_PLO  = 2'd1;
    localparam logic [1:0] ADR_PHI  = 2'd2;

    localparam int CB_WIDE  = 0;
    localparam int CB_GATE  = 1;
    localparam int CB_SRC_L = 2;
    localparam int CB_CLR   = 7;

endpackage

// File: rtl/duo_timer_srcsel.sv
module duo_timer_srcsel #(
    parameter int SRC_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SRC_W-1:0]            sel_i,
    input  logic [(1 << SRC_W) - 2 : 0] lines_i,
    output logic                        edge_o
);
    localparam int NPAD = 1 << SRC_W;

    logic [NPAD-1:0] padded;
    logic            picked;
    logic            smp_q;
    logic            smp_prev_q;

    // the all-ones code lands on the padding bit, which is tied low
    assign padded = {1'b0, lines_i};
    assign picked = padded[sel_i];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q      <= 1'b0;
            smp_prev_q <= 1'b0;
        end else begin
            smp_q      <= picked;
            smp_prev_q <= smp_q;
        end
    end

    assign edge_o = smp_q & ~smp_prev_q;

    // R8: the no-source code never yields an edge
    a_r8_no_source_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_i) == '1) |-> !edge_o);

endmodule

// File: rtl/duo_timer_gate.sv
module duo_timer_gate
    import duo_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en_i,
    input  logic clr_wr_i,
    input  logic edge_i,
    output logic free_o,
    output logic hold_o,
    output logic running_o
);
    gate_st_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= GS_IDLE_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GS_IDLE_FREE: begin
                if (gate_en_i) st_d = GS_PARKED;             // enable_gate
            end
            GS_PARKED: begin
                if (!gate_en_i)     st_d = GS_IDLE_FREE;     // disable_gate
                else if (clr_wr_i)  st_d = GS_PARKED;        // clear beats edge
                else if (edge_i)    st_d = GS_RUNNING;       // fire
            end
            GS_RUNNING: begin
                if (!gate_en_i)     st_d = GS_IDLE_FREE;     // disable_gate
                else if (clr_wr_i)  st_d = GS_PARKED;        // rearm
            end
            default: st_d = GS_IDLE_FREE;
        endcase
    end

    always_comb begin
        free_o    = 1'b0;
        hold_o    = 1'b0;
        running_o = 1'b0;
        unique case (st_q)
            GS_IDLE_FREE: free_o    = 1'b1;
            GS_PARKED:    hold_o    = 1'b1;
            GS_RUNNING:   running_o = 1'b1;
            default:      free_o    = 1'b1;
        endcase
    end

    // R12: a clear strobe never lets the machine be running afterwards
    a_r12_clear_beats_edge: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i |=> (st_q != GS_RUNNING));

    // R9: a parked machine only starts through an edge
    a_r9_start_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GS_PARKED && !edge_i) |=> (st_q != GS_RUNNING));

endmodule

// File: rtl/duo_timer_half.sv
module duo_timer_half #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_o <= '0;
        else if (clr_i) cnt_o <= '0;
        else if (inc_i) cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/duo_timer.sv
module duo_timer
    import duo_timer_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int SRC_W  = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_addr,
    input  logic [HALF_W-1:0]           wr_data,
    input  logic [(1 << SRC_W) - 2 : 0] sync_in,
    output logic [HALF_W-1:0]           cnt_lo_o,
    output logic [HALF_W-1:0]           cnt_hi_o,
    output logic                        lo_flag,
    output logic                        hi_flag,
    output logic                        sync_out,
    output logic                        trig_status
);
    localparam int NHALF = 2;
    localparam int SRC_H = CB_SRC_L + SRC_W - 1;

    // control and period registers
    logic              wide_q, gate_q;
    logic [SRC_W-1:0]  sel_q;
    logic [HALF_W-1:0] per_lo_q, per_hi_q;

    logic ctrl_wr, mode_flip, clr_wr;

    assign ctrl_wr   = wr_en && (wr_addr == ADR_CTRL);
    assign mode_flip = ctrl_wr && (wr_data[CB_WIDE] != wide_q);
    assign clr_wr    = ctrl_wr && wr_data[CB_CLR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q   <= 1'b0;
            gate_q   <= 1'b0;
            sel_q    <= '1;
            per_lo_q <= '1;
            per_hi_q <= '1;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_CTRL: begin
                    wide_q <= wr_data[CB_WIDE];
                    gate_q <= wr_data[CB_GATE];
                    sel_q  <= wr_data[SRC_H:CB_SRC_L];
                end
                ADR_PLO: per_lo_q <= wr_data;
                ADR_PHI: per_hi_q <= wr_data;
                default: ;
            endcase
        end
    end

    // event source and gate machine
    logic sync_edge, g_free, g_hold, g_run;

    duo_timer_srcsel #(.SRC_W(SRC_W)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel_q),
        .lines_i (sync_in),
        .edge_o  (sync_edge)
    );

    duo_timer_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_en_i (gate_q),
        .clr_wr_i  (clr_wr),
        .edge_i    (sync_edge),
        .free_o    (g_free),
        .hold_o    (g_hold),
        .running_o (g_run)
    );

    // counter halves
    logic [HALF_W-1:0] cnt [NHALF];
    logic [NHALF-1:0]  h_clr, h_inc;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        duo_timer_half #(.W(HALF_W)) u_half (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (h_clr[h]),
            .inc_i (h_inc[h]),
            .cnt_o (cnt[h])
        );
    end

    logic active, prim_zero, lo_match, hi_match, full_match, lo_ovf;
    logic lo_flag_d, hi_flag_d, sync_d;

    assign active     = ~g_hold;
    assign prim_zero  = mode_flip | clr_wr | g_hold | (sync_edge & g_free);
    assign lo_match   = (cnt[0] == per_lo_q);
    assign hi_match   = (cnt[1] == per_hi_q);
    assign full_match = lo_match & hi_match;
    assign lo_ovf     = (cnt[0] == '1);

    always_comb begin
        if (wide_q) begin
            h_clr[0]  = prim_zero | (active & full_match);
            h_inc[0]  = active;
            h_clr[1]  = prim_zero | (active & full_match);
            h_inc[1]  = active & lo_ovf;
            lo_flag_d = 1'b0;
            hi_flag_d = active & full_match & ~prim_zero;
            sync_d    = active & full_match & ~prim_zero;
        end else begin
            h_clr[0]  = prim_zero | (active & lo_match);
            h_inc[0]  = active;
            h_clr[1]  = mode_flip | hi_match;
            h_inc[1]  = 1'b1;
            lo_flag_d = active & lo_match & ~prim_zero;
            hi_flag_d = hi_match & ~mode_flip;
            sync_d    = active & lo_match & ~prim_zero;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_flag  <= 1'b0;
            hi_flag  <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            lo_flag  <= lo_flag_d;
            hi_flag  <= hi_flag_d;
            sync_out <= sync_d;
        end
    end

    assign cnt_lo_o    = cnt[0];
    assign cnt_hi_o    = cnt[1];
    assign trig_status = g_run;

    // R3: split-mode wrap on the clock after a match, with the flag
    a_r3_split_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_q && !g_hold && lo_match && !prim_zero) |=> (cnt[0] == '0 && lo_flag && sync_out));

    // R5: carry from an all-ones low half
    a_r5_cascade_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_q && !g_hold && lo_ovf && !full_match && !prim_zero)
            |=> (cnt[1] == $past(cnt[1]) + 1'b1 && cnt[0] == '0));

    // R6: no low flag while cascaded
    a_r6_wide_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wide_q |-> !lo_flag);

    // R7: restart edge zeroes the primary count
    a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (g_free && sync_edge) |=> (cnt[0] == '0 && !lo_flag));

    // R9: parked means zero
    a_r9_parked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        g_hold |=> (cnt[0] == '0));

    // R11: clear strobe drops status and count
    a_r11_clear_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (!trig_status && cnt[0] == '0));

endmodule

// File: tb/sim_duo_timer.sv
`timescale 1ns/1ps
module sim_duo_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [30:0] sync_in = '0;
    logic [15:0] cnt_lo_o, cnt_hi_o;
    logic        lo_flag, hi_flag, sync_out, trig_status;

    duo_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_in(sync_in), .cnt_lo_o(cnt_lo_o),
        .cnt_hi_o(cnt_hi_o), .lo_flag(lo_flag), .hi_flag(hi_flag),
        .sync_out(sync_out), .trig_status(trig_status)
    );

    always #2.5 clk = ~clk;

    int now = 0;
    always @(posedge clk) now++;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // observation kinds
    localparam int K_LO = 0, K_HI = 1, K_LOF = 2, K_HIF = 3, K_SO = 4, K_TS = 5;

    typedef struct {
        int          cyc;
        int          kind;
        logic [31:0] val;
        string       req;
    } item_t;

    item_t sb[$];

    function automatic logic [31:0] observe(int kind);
        case (kind)
            K_LO:    return {16'd0, cnt_lo_o};
            K_HI:    return {16'd0, cnt_hi_o};
            K_LOF:   return {31'd0, lo_flag};
            K_HIF:   return {31'd0, hi_flag};
            K_SO:    return {31'd0, sync_out};
            default: return {31'd0, trig_status};
        endcase
    endfunction

    task automatic expect_at(int cyc, int kind, logic [31:0] val, string req);
        item_t it;
        it.cyc = cyc; it.kind = kind; it.val = val; it.req = req;
        sb.push_back(it);
    endtask

    // monitor: compares everything due in this cycle, between clock edges
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == now) begin
                logic [31:0] got;
                got = observe(sb[i].kind);
                checks++;
                if (got !== sb[i].val) begin
                    errors++;
                    $display("FAIL %s cycle %0d kind %0d actual %0h expected %0h",
                             sb[i].req, now, sb[i].kind, got, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_until(int c);
        while (now < c) step(1);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] ctrl(bit wide, bit gate, int src, bit clr);
        return {8'd0, clr, src[4:0], gate, wide};
    endfunction

    initial begin
        int t0, k, w, tt, k2;
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        k = now;
        expect_at(k, K_LO, 0, "R1");
        expect_at(k, K_HI, 0, "R1");
        expect_at(k, K_LOF, 0, "R1");
        expect_at(k, K_HIF, 0, "R1");
        expect_at(k, K_TS, 0, "R1");
        expect_at(k + 1, K_LO, 1, "R1");
        step(2);

        // split mode: low period 4, high period 6, zeroed by two mode flips (R2)
        wr(2'd1, 16'd4);
        wr(2'd2, 16'd6);
        wr(2'd0, ctrl(1, 0, 31, 0));
        wr(2'd0, ctrl(0, 0, 31, 0));
        t0 = now;
        expect_at(t0, K_HI, 0, "R2");
        for (int i = 0; i <= 12; i++) begin
            expect_at(t0 + i, K_LO, i % 5, "R3");
            expect_at(t0 + i, K_LOF, (i > 0 && i % 5 == 0), "R3");
            expect_at(t0 + i, K_SO, (i > 0 && i % 5 == 0), "R3");
        end
        for (int i = 1; i <= 16; i++) begin
            expect_at(t0 + i, K_HI, i % 7, "R4");
            expect_at(t0 + i, K_HIF, (i % 7 == 0), "R4");
        end
        wait_until(t0 + 18);

        // cascade mode: period 0x0001_0002
        wr(2'd2, 16'd1);
        wr(2'd1, 16'd2);
        wr(2'd0, ctrl(1, 0, 31, 0));
        t0 = now;
        expect_at(t0, K_LO, 0, "R2");
        expect_at(t0 + 3, K_LOF, 0, "R6");
        expect_at(t0 + 65535, K_LO, 32'hFFFF, "R5");
        expect_at(t0 + 65535, K_HI, 0, "R5");
        expect_at(t0 + 65536, K_LO, 0, "R5");
        expect_at(t0 + 65536, K_HI, 1, "R5");
        expect_at(t0 + 65538, K_LO, 2, "R6");
        expect_at(t0 + 65538, K_HIF, 0, "R6");
        expect_at(t0 + 65539, K_LO, 0, "R6");
        expect_at(t0 + 65539, K_HI, 0, "R6");
        expect_at(t0 + 65539, K_HIF, 1, "R6");
        expect_at(t0 + 65539, K_SO, 1, "R6");
        expect_at(t0 + 65539, K_LOF, 0, "R6");
        expect_at(t0 + 65540, K_HIF, 0, "R6");
        wait_until(t0 + 65542);

        // restart mode on line 5
        wr(2'd1, 16'd100);
        wr(2'd2, 16'd2);
        wr(2'd0, ctrl(0, 0, 5, 0));
        t0 = now;
        wait_until(t0 + 11);
        k = now;
        sync_in[5] = 1'b1;
        expect_at(k + 1, K_LO, 12, "R7");
        expect_at(k + 2, K_LO, 0, "R7");
        expect_at(k + 3, K_LO, 1, "R7");
        expect_at(k + 6, K_LO, 4, "R7");
        expect_at(k + 2, K_HI, 1, "R4");
        wait_until(k + 7);
        sync_in = '0;
        step(2);

        // no-source code: edges on every line are ignored
        wr(2'd0, ctrl(0, 0, 31, 1));
        t0 = now;
        wait_until(t0 + 5);
        k = now;
        sync_in = '1;
        expect_at(k + 2, K_LO, 7, "R8");
        expect_at(k + 3, K_LO, 8, "R8");
        wait_until(k + 4);
        sync_in = '0;
        step(2);

        // restart landing on the wrap cycle
        wr(2'd1, 16'd9);
        wr(2'd0, ctrl(0, 0, 5, 1));
        t0 = now;
        wait_until(t0 + 8);
        k = now;
        sync_in[5] = 1'b1;
        expect_at(k + 1, K_LO, 9, "R10");
        expect_at(k + 2, K_LO, 0, "R10");
        expect_at(k + 2, K_LOF, 0, "R10");
        expect_at(k + 2, K_SO, 0, "R10");
        expect_at(k + 11, K_LO, 9, "R10");
        expect_at(k + 12, K_LOF, 1, "R10");
        wait_until(k + 13);
        sync_in = '0;
        step(2);

        // gated start on line 3
        wr(2'd1, 16'd100);
        wr(2'd0, ctrl(0, 1, 3, 0));
        w = now;
        expect_at(w + 3, K_LO, 0, "R9");
        expect_at(w + 5, K_LO, 0, "R9");
        expect_at(w + 5, K_TS, 0, "R9");
        wait_until(w + 6);
        k = now;
        sync_in[3] = 1'b1;
        expect_at(k + 2, K_TS, 1, "R9");
        expect_at(k + 2, K_LO, 0, "R9");
        expect_at(k + 3, K_LO, 1, "R9");
        expect_at(k + 5, K_LO, 3, "R9");
        expect_at(k + 8, K_LO, 6, "R9");
        expect_at(k + 8, K_TS, 1, "R9");
        wait_until(k + 4);
        sync_in[3] = 1'b0;
        wait_until(k + 8);
        wr(2'd0, ctrl(0, 1, 3, 1));
        tt = now;
        expect_at(tt, K_TS, 0, "R11");
        expect_at(tt, K_LO, 0, "R11");
        expect_at(tt + 4, K_LO, 0, "R11");
        wait_until(tt + 5);

        // clear strobe captured together with an edge
        k2 = now;
        sync_in[3] = 1'b1;
        step(1);
        wr(2'd0, ctrl(0, 1, 3, 1));
        expect_at(k2 + 2, K_TS, 0, "R12");
        expect_at(k2 + 2, K_LO, 0, "R12");
        expect_at(k2 + 6, K_TS, 0, "R12");
        expect_at(k2 + 6, K_LO, 0, "R12");
        wait_until(k2 + 8);
        sync_in = '0;
        step(2);

        if (!done) begin
            done = 1'b1;
            foreach (sb[i]) begin
                checks++;
                errors++;
                $display("FAIL %s never compared at cycle %0d actual none expected %0h",
                         sb[i].req, sb[i].cyc, sb[i].val);
            end
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule